// File: doc/BRIEF.md
# SPI Transaction Command and Event Controller

This block is the register-facing side of an SPI master. Software reaches it over a simple 32-bit register bus. Through that bus it sets a global enable, a loopback flag and two FIFO fill thresholds. It fills a byte-wide transmit FIFO, drains a byte-wide receive FIFO, and reads an event word. That word combines live FIFO levels with latched, write-one-to-clear flags. A mask selects which flags drive the interrupt.

A write to the command register starts a transaction. The command word names one of up to four chip-selects and holds a byte count minus one. The block drives the selected chip-select low from that write until the last byte of the transaction has come back, then releases it. The serial shifting is done by an external engine. The block offers it transmit bytes through a valid/ready pair and accepts one received byte per valid pulse. Each received byte counts as one completed byte of the transaction.

Each chip-select has a 32-bit configuration word. The word for the active chip-select is presented to the engine. These words are locked while the block is enabled.

Top module: `spi_cmd_ctrl`

## Requirements
- R1: After reset, the mode word (byte address 0x00) reads 0x0000_0403, the mask word (0x08) reads 0, the event word (0x04) reads 0x0000_1100, every `cs_n` is high, and `irq` and `loop_en` are low.
- R2: A word write to the transmit address 0x10 pushes four bytes, taking bits 31:24 first. With `bus_byte` set, the write pushes only bits 7:0. Bytes beyond the FIFO depth are dropped. The transmit fill level reads in event bits 21:16.
- R3: A word read of the receive address 0x14 pops up to four bytes, with the oldest byte in bits 31:24 and missing bytes read as zero. A byte read pops one byte into bits 7:0. The receive fill level reads in event bits 29:24.
- R4: A write to the command address 0x0C carries the chip-select in bits 31:30 and the length in the low bits. It is acted on only while mode bit 31 is set and no transaction is running. When acted on, it drives that chip-select low and moves length+1 bytes. A command write at any other time is ignored.
- R5: The chip-select goes high in the cycle after the last received byte of a transaction, and event bit 14 (done) latches.
- R6: Transmit bytes are offered to the engine in FIFO order, only during a transaction, and at most length+1 of them per transaction.
- R7: The live event bits follow the FIFOs: bit 9 is set when the receive FIFO is non-empty, bit 8 when the transmit FIFO is not full, bit 13 when the receive level exceeds mode bits 5:0, and bit 12 when the transmit level is below mode bits 13:8.
- R8: A received byte that arrives while the receive FIFO is full is dropped and latches event bit 11 (overflow).
- R9: Writing ones to the event word clears the matching latched bits (14 and 11). The live bits are unaffected.
- R10: `irq` is high exactly when some event bit 15:0 is set together with the same bit of the mask.
- R11: The configuration word of chip-select i sits at 0x20+4*i. It can be written only while mode bit 31 is clear. `cs_cfg` shows the word of the most recently started chip-select.
- R12: Mode bit 30 drives `loop_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive FIFO at 0x14) |
| bus_addr | input | 8 | Byte address |
| bus_byte | input | 1 | Byte-sized access to the FIFO addresses |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| irq | output | 1 | Masked event interrupt |
| loop_en | output | 1 | Loopback request to the engine |
| cs_n | output | NUM_CS | Active-low chip-selects |
| cs_cfg | output | 32 | Configuration word of the current chip-select |
| eng_tx_valid | output | 1 | Transmit byte offered |
| eng_tx_ready | input | 1 | Engine takes the offered byte |
| eng_tx_data | output | 8 | Offered transmit byte |
| eng_rx_valid | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |

## Verification
The bench builds the block with FIFO_DEPTH=8, LEN_W=4 and NUM_CS=4. The shallow FIFOs let a few bus writes reach the full and drop points, and a single transaction of eight bytes fills the receive side exactly. A second, overlapping transaction drives it into overflow. The 4-bit length keeps each transaction short, so transactions that end early, commands issued while busy and commands issued while disabled can all be walked cycle by cycle, with the expected event words built from their field positions.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
   localparam logic [7:0] A_MODE  = 8'h00;
   localparam logic [7:0] A_EVENT = 8'h04;
   localparam logic [7:0] A_MASK  = 8'h08;
   localparam logic [7:0] A_CMD   = 8'h0C;
   localparam logic [7:0] A_TXQ   = 8'h10;
   localparam logic [7:0] A_RXQ   = 8'h14;
   localparam logic [7:0] A_CSCFG = 8'h20;

   localparam int MB_EN   = 31;
   localparam int MB_LOOP = 30;

   localparam int EB_TNF  = 8;
   localparam int EB_RNE  = 9;
   localparam int EB_OVF  = 11;
   localparam int EB_TXT  = 12;
   localparam int EB_RXT  = 13;
   localparam int EB_DONE = 14;

   localparam logic [31:0] MODE_RST   = 32'h0000_0403;
   localparam logic [31:0] MODE_WMASK = 32'hC000_3F3F;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
   parameter int DEPTH = 32,
   parameter int LANES = 4,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         push_n,
   input  logic [8*LANES-1:0] push_word,
   input  logic [2:0]         pop_n,
   output logic [CW-1:0]      count,
   output logic [8*LANES-1:0] head,
   output logic               push_drop
);
   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] cnt, free_c, acc_c, pop_c;

   if (LANES > 7 || CW < 3) begin : g_bad_cfg
      $error("spi_byte_fifo: LANES must be below 8 and DEPTH at least 4");
   end

   always_comb begin
      free_c    = CW'(DEPTH) - cnt;
      push_drop = CW'(push_n) > free_c;
      acc_c     = push_drop ? free_c : CW'(push_n);
      pop_c     = (CW'(pop_n) > cnt) ? cnt : CW'(pop_n);
   end

   always_ff @(posedge clk) begin
      for (int k = 0; k < LANES; k++) begin
         if (CW'(k) < acc_c) mem[wptr + AW'(k)] <= push_word[8*(LANES-1-k) +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         wptr <= wptr + AW'(acc_c);
         rptr <= rptr + AW'(pop_c);
         cnt  <= cnt + acc_c - pop_c;
      end
   end

   for (genvar k = 0; k < LANES; k++) begin : g_head
      assign head[8*(LANES-1-k) +: 8] = mem[rptr + AW'(k)];
   end

   assign count = cnt;

   // R2 / R3: the fill level never passes the depth
   a_r2_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
endmodule

// File: rtl/spi_txn_seq.sv
module spi_txn_seq #(
   parameter int NUM_CS = 4,
   parameter int LEN_W  = 16,
   localparam int CNT_W = LEN_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              cmd_go,
   input  logic [1:0]        cmd_cs,
   input  logic [LEN_W-1:0]  cmd_len,
   input  logic              tx_avail,
   input  logic              eng_tx_ready,
   input  logic              eng_rx_valid,
   output logic              active,
   output logic [1:0]        cs_sel,
   output logic [NUM_CS-1:0] cs_n,
   output logic              eng_tx_valid,
   output logic              tx_pop,
   output logic              rx_take,
   output logic              finish
);
   logic [CNT_W-1:0] tx_left, rx_left;
   logic             start;

   assign start        = cmd_go && enable && !active;
   assign eng_tx_valid = active && enable && tx_avail && (tx_left != '0);
   assign tx_pop       = eng_tx_valid && eng_tx_ready;
   assign rx_take      = active && eng_rx_valid && (rx_left != '0);
   assign finish       = rx_take && (rx_left == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         cs_sel  <= '0;
         tx_left <= '0;
         rx_left <= '0;
      end else if (start) begin
         active  <= 1'b1;
         cs_sel  <= cmd_cs;
         tx_left <= {1'b0, cmd_len} + CNT_W'(1);
         rx_left <= {1'b0, cmd_len} + CNT_W'(1);
      end else begin
         if (tx_pop)  tx_left <= tx_left - CNT_W'(1);
         if (rx_take) rx_left <= rx_left - CNT_W'(1);
         if (finish)  active  <= 1'b0;
      end
   end

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign cs_n[i] = !(active && cs_sel == 2'(i));
   end

   // R4: at most one chip-select is driven low
   a_r4_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));
   // R4: the selected chip-select holds until the transaction ends
   a_r4_cs_hold: assert property (@(posedge clk) disable iff (!rst_n)
      active && !finish |=> active && $stable(cs_sel));
   // R5: the last received byte releases the chip-select
   a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> !active);
   // R6: a byte is offered only while a transaction runs
   a_r6_offer_active: assert property (@(posedge clk) disable iff (!rst_n)
      eng_tx_valid |-> active);
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
   import spi_cmd_pkg::*;
#(
   parameter int FIFO_DEPTH = 32,
   parameter int NUM_CS     = 4,
   parameter int LEN_W      = 16,
   localparam int FCW = $clog2(FIFO_DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_addr,
   input  logic              bus_byte,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   output logic              loop_en,
   output logic [NUM_CS-1:0] cs_n,
   output logic [31:0]       cs_cfg,
   output logic              eng_tx_valid,
   input  logic              eng_tx_ready,
   output logic [7:0]        eng_tx_data,
   input  logic              eng_rx_valid,
   input  logic [7:0]        eng_rx_data
);
   if (FIFO_DEPTH < 4 || FIFO_DEPTH > 32 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spi_cmd_ctrl: FIFO_DEPTH must be a power of two from 4 to 32");
   end
   if (NUM_CS < 1 || NUM_CS > 4) begin : g_bad_cs
      $error("spi_cmd_ctrl: NUM_CS must be 1 to 4");
   end
   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
      $error("spi_cmd_ctrl: LEN_W must be 1 to 16");
   end

   logic [31:0]    mode_q, cmd_q, ev_word, rx_word;
   logic [15:0]    mask_q;
   logic           ev_done, ev_ovf, mode_en;
   logic [31:0]    csm [NUM_CS];
   logic [FCW-1:0] tx_cnt, rx_cnt;
   logic [31:0]    tx_head, rx_head;
   logic           tx_drop, rx_drop;
   logic           wr_mode, wr_ev, wr_mask, wr_cmd, wr_tx, rd_rx;
   logic           active, tx_pop, rx_take, finish;
   logic [1:0]     cs_sel;
   logic [2:0]     tx_push_n, rx_pop_n;
   logic           unused_tx;

   assign mode_en = mode_q[MB_EN];
   assign loop_en = mode_q[MB_LOOP];
   assign wr_mode = bus_wr && bus_addr == A_MODE;
   assign wr_ev   = bus_wr && bus_addr == A_EVENT;
   assign wr_mask = bus_wr && bus_addr == A_MASK;
   assign wr_cmd  = bus_wr && bus_addr == A_CMD;
   assign wr_tx   = bus_wr && bus_addr == A_TXQ;
   assign rd_rx   = bus_rd && bus_addr == A_RXQ;

   assign tx_push_n = wr_tx ? (bus_byte ? 3'd1 : 3'd4) : 3'd0;
   assign rx_pop_n  = rd_rx ? (bus_byte ? 3'd1 : 3'd4) : 3'd0;

   spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .LANES(4)) u_txq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_n    (tx_push_n),
      .push_word (bus_byte ? {bus_wdata[7:0], 24'h0} : bus_wdata),
      .pop_n     ({2'b00, tx_pop}),
      .count     (tx_cnt),
      .head      (tx_head),
      .push_drop (tx_drop)
   );

   spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .LANES(4)) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_n    ({2'b00, rx_take}),
      .push_word ({eng_rx_data, 24'h0}),
      .pop_n     (rx_pop_n),
      .count     (rx_cnt),
      .head      (rx_head),
      .push_drop (rx_drop)
   );

   spi_txn_seq #(.NUM_CS(NUM_CS), .LEN_W(LEN_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (mode_en),
      .cmd_go       (wr_cmd),
      .cmd_cs       (bus_wdata[31:30]),
      .cmd_len      (bus_wdata[LEN_W-1:0]),
      .tx_avail     (tx_cnt != '0),
      .eng_tx_ready (eng_tx_ready),
      .eng_rx_valid (eng_rx_valid),
      .active       (active),
      .cs_sel       (cs_sel),
      .cs_n         (cs_n),
      .eng_tx_valid (eng_tx_valid),
      .tx_pop       (tx_pop),
      .rx_take      (rx_take),
      .finish       (finish)
   );

   assign eng_tx_data = tx_head[31:24];
   assign unused_tx   = ^{tx_head[23:0], tx_drop, active};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_RST;
         mask_q  <= '0;
         cmd_q   <= '0;
         ev_done <= 1'b0;
         ev_ovf  <= 1'b0;
      end else begin
         if (wr_mode) mode_q <= bus_wdata & MODE_WMASK;
         if (wr_mask) mask_q <= bus_wdata[15:0];
         if (wr_cmd)  cmd_q  <= bus_wdata;
         if (finish)                          ev_done <= 1'b1;
         else if (wr_ev && bus_wdata[EB_DONE]) ev_done <= 1'b0;
         if (rx_take && rx_drop)              ev_ovf  <= 1'b1;
         else if (wr_ev && bus_wdata[EB_OVF])  ev_ovf  <= 1'b0;
      end
   end

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cscfg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) csm[i] <= '0;
         else if (bus_wr && !mode_en && bus_addr == A_CSCFG + 8'(4*i)) csm[i] <= bus_wdata;
      end
   end

   always_comb begin
      cs_cfg = '0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (cs_sel == 2'(i)) cs_cfg = csm[i];
      end
   end

   always_comb begin
      ev_word = '0;
      ev_word[29:24]   = 6'(rx_cnt);
      ev_word[21:16]   = 6'(tx_cnt);
      ev_word[EB_DONE] = ev_done;
      ev_word[EB_RXT]  = 6'(rx_cnt) > mode_q[5:0];
      ev_word[EB_TXT]  = 6'(tx_cnt) < mode_q[13:8];
      ev_word[EB_OVF]  = ev_ovf;
      ev_word[EB_RNE]  = rx_cnt != '0;
      ev_word[EB_TNF]  = tx_cnt != FCW'(FIFO_DEPTH);
   end

   assign irq = |(ev_word[15:0] & mask_q);

   always_comb begin
      for (int k = 0; k < 4; k++) begin
         rx_word[8*(3-k) +: 8] = (FCW'(k) < rx_cnt) ? rx_head[8*(3-k) +: 8] : 8'h00;
      end
      if (bus_byte) rx_word = {24'h0, rx_word[31:24]};
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_MODE:  bus_rdata = mode_q;
         A_EVENT: bus_rdata = ev_word;
         A_MASK:  bus_rdata = {16'h0, mask_q};
         A_CMD:   bus_rdata = cmd_q;
         A_RXQ:   bus_rdata = rx_word;
         default: begin
            for (int i = 0; i < NUM_CS; i++) begin
               if (bus_addr == A_CSCFG + 8'(4*i)) bus_rdata = csm[i];
            end
         end
      endcase
   end

   // R11: the configuration words do not move while enabled
   a_r11_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
      mode_en |=> $stable(csm[0]));
   // R8: an overflow flag appears only after a dropped byte or with one already held
   a_r8_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ev_ovf) |-> $past(rx_take && rx_cnt == FCW'(FIFO_DEPTH)));
endmodule

// File: tb/spi_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module spi_cmd_ctrl_bench;
   localparam int NCS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_byte = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        irq, loop_en, eng_tx_valid, eng_tx_ready = 1'b0, eng_rx_valid = 1'b0;
   logic [NCS-1:0] cs_n;
   logic [31:0] cs_cfg;
   logic [7:0]  eng_tx_data, eng_rx_data = '0;

   int errors = 0, checks = 0;
   bit done_flag = 0;

   always #2 clk = ~clk;

   spi_cmd_ctrl #(.FIFO_DEPTH(8), .NUM_CS(NCS), .LEN_W(4)) u_spi_cmd_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_byte(bus_byte), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
      .loop_en(loop_en), .cs_n(cs_n), .cs_cfg(cs_cfg), .eng_tx_valid(eng_tx_valid),
      .eng_tx_ready(eng_tx_ready), .eng_tx_data(eng_tx_data), .eng_rx_valid(eng_rx_valid),
      .eng_rx_data(eng_rx_data));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic b = 1'b0);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_byte = b;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_byte = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic b, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a; bus_byte = b;
      #1 d = bus_rdata;
      @(posedge clk); #1;
      bus_rd = 1'b0; bus_byte = 1'b0;
   endtask

   task automatic rchk(input string req, input logic [7:0] a, input logic b, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, b, d);
      chk(req, d, exp);
   endtask

   initial begin
      #(100000 * 4);
      if (!done_flag) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] txe [8];
      txe = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'hAA, 8'hBB, 8'hCC};
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rchk("R1 mode", 8'h00, 1'b0, 32'h0000_0403);
      rchk("R1 mask", 8'h08, 1'b0, 32'h0);
      rchk("R1 event", 8'h04, 1'b0, 32'h0000_1100);
      chk("R1 cs_n", 32'(cs_n), 32'hF);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 loop_en", 32'(loop_en), 0);

      // R2 transmit pushes and drop past full (depth 8)
      wr(8'h10, 32'h1122_3344);
      rchk("R2 txcnt after word", 8'h04, 1'b0, 32'h0004_0100);
      wr(8'h10, 32'h0000_0055, 1'b1);
      rchk("R2 txcnt after byte", 8'h04, 1'b0, 32'h0005_0100);
      wr(8'h10, 32'hAABB_CCDD);
      rchk("R2 R7 full, not-full clear", 8'h04, 1'b0, 32'h0008_0000);

      // R4 R6 transaction of 8 bytes on chip-select 2
      wr(8'h00, 32'h8000_0403);
      eng_tx_ready = 1'b1;
      wr(8'h0C, 32'h8000_0007);
      chk("R4 cs2 asserted", 32'(cs_n), 32'hB);
      for (int i = 0; i < 8; i++) begin
         eng_rx_valid = 1'b1; eng_rx_data = txe[i] ^ 8'hFF;
         #1;
         chk("R6 tx offered", 32'(eng_tx_valid), 1);
         chk("R2 R6 tx order", 32'(eng_tx_data), 32'(txe[i]));
         @(posedge clk); #1;
      end
      eng_rx_valid = 1'b0;
      chk("R5 cs released", 32'(cs_n), 32'hF);
      rchk("R5 R7 event after txn", 8'h04, 1'b0, 32'h0800_7300);

      // R3 receive pops
      rchk("R3 word read", 8'h14, 1'b0, 32'hEEDD_CCBB);
      rchk("R3 byte read", 8'h14, 1'b1, 32'h0000_00AA);
      rchk("R3 short word read", 8'h14, 1'b0, 32'h5544_3300);
      rchk("R3 R7 event drained", 8'h04, 1'b0, 32'h0000_5100);

      // R9 write-one-to-clear
      wr(8'h04, 32'hFFFF_FFFF);
      rchk("R9 latched cleared, live kept", 8'h04, 1'b0, 32'h0000_1100);

      // R10 interrupt masking
      wr(8'h08, 32'h0000_0100);
      chk("R10 irq on not-full", 32'(irq), 1);
      wr(8'h08, 32'h0000_4000);
      chk("R10 irq off with done clear", 32'(irq), 0);
      wr(8'h08, 32'h0);

      // R6 length limit: 2-byte transaction with 8 queued
      wr(8'h10, 32'h0102_0304);
      wr(8'h10, 32'h0506_0708);
      wr(8'h0C, 32'h0000_0001);
      chk("R4 cs0 asserted", 32'(cs_n), 32'hE);
      for (int i = 0; i < 2; i++) begin
         eng_rx_valid = 1'b1; eng_rx_data = 8'h10 + 8'(i);
         #1 chk("R6 short txn data", 32'(eng_tx_data), 32'(i + 1));
         @(posedge clk); #1;
      end
      eng_rx_valid = 1'b0;
      chk("R6 no offer after length", 32'(eng_tx_valid), 0);
      chk("R5 cs0 released", 32'(cs_n), 32'hF);

      // R8 overflow, R4 busy command ignored
      eng_tx_ready = 1'b0;
      wr(8'h0C, 32'h4000_0007);
      chk("R4 cs1 asserted", 32'(cs_n), 32'hD);
      wr(8'h0C, 32'hC000_0000);
      chk("R4 busy command ignored", 32'(cs_n), 32'hD);
      for (int i = 0; i < 8; i++) begin
         eng_rx_valid = 1'b1; eng_rx_data = 8'h20 + 8'(i);
         @(posedge clk); #1;
      end
      eng_rx_valid = 1'b0;
      chk("R5 cs1 released after 8", 32'(cs_n), 32'hF);
      rchk("R8 overflow event", 8'h04, 1'b0, 32'h0806_6B00);
      wr(8'h08, 32'h0000_0800);
      chk("R10 R8 irq on overflow", 32'(irq), 1);
      wr(8'h04, 32'h0000_0800);
      rchk("R9 only overflow cleared", 8'h04, 1'b0, 32'h0806_6300);
      chk("R10 irq after clear", 32'(irq), 0);

      // R11 configuration lock
      wr(8'h24, 32'hDEAD_BEEF);
      rchk("R11 locked while enabled", 8'h24, 1'b0, 32'h0);
      wr(8'h00, 32'h0000_0403);
      wr(8'h24, 32'hDEAD_BEEF);
      rchk("R11 written while disabled", 8'h24, 1'b0, 32'hDEAD_BEEF);
      chk("R11 cs_cfg of cs1", cs_cfg, 32'hDEAD_BEEF);
      wr(8'h0C, 32'h0000_0000);
      chk("R4 disabled command ignored", 32'(cs_n), 32'hF);

      // R12 loopback and R7 thresholds
      wr(8'h00, 32'h4000_0A07);
      chk("R12 loop_en", 32'(loop_en), 1);
      rchk("R12 mode readback", 8'h00, 1'b0, 32'h4000_0A07);
      rchk("R7 new thresholds", 8'h04, 1'b0, 32'h0806_7300);

      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule